// File: doc/BRIEF.md
# Class-Priority Wormhole Output Scheduler

This block is the output side of one port of a mesh router. Several input ports, after route computation and the crossbar, each present at most one flit per cycle aimed at this output, tagged with one of a fixed number of service classes. Each class has separate buffering at the downstream router. The block keeps a count of free downstream slots for every class. Each cycle it grants at most one flit onto the link. A flit can be granted only when its class has a free slot. The lowest-numbered class wins. Among inputs of the same class, a rotating pointer decides.

Packets are wormhole-switched. Once a class accepts a head flit from one input, that class stays bound to that input until the packet's tail flit has gone. Flits of other classes can still use the link between the flits of a bound packet. The granted flit is registered and appears on the link one cycle after the grant. Credit-return pulses from downstream refill the counts.

Top module: `qos_wh_sched`

## Requirements
- R1: During synchronous reset and after it, every class's free-slot count equals DEPTH, no class is bound, every round-robin pointer is 0, and `out_valid` is low until a grant occurs.
- R2: A flit is never granted while its class's free-slot count is 0.
- R3: A grant decrements its class's count at the clock edge ending the grant cycle. A `cred_ret` pulse increments it at the same edge. A grant and a return in the same cycle leave the count unchanged. A return at DEPTH is ignored, so the count never exceeds DEPTH. A return does not make a grant possible in the cycle in which it arrives.
- R4: Among eligible requests of different classes, the lowest class number is granted.
- R5: Among eligible requests of one class, the winner is the first input at or after that class's pointer, wrapping modulo NIN. After every grant in a class, its pointer becomes the winner index plus one, modulo NIN.
- R6: Flit kind encoding is 00 body, 01 head, 10 tail and 11 single-flit packet. On an unbound class, only head (01) and single (11) flits are eligible. Body and tail flits on an unbound class are not granted.
- R7: Granting a head flit binds its class to that input. While the class is bound, only body or tail flits from the bound input are eligible in that class. Granting the tail flit releases the binding. Single-flit packets leave the class unbound.
- R8: While a class is bound, an eligible flit of a lower-numbered class is granted ahead of the bound packet's next flit, and the binding is kept.
- R9: `in_ready` is one-hot or zero and asserts only for a requesting input, in the same cycle as the grant. In the next cycle `out_valid` is high and carries that flit's class, kind and data. If there was no grant, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NIN | Per-input flit present |
| req_cls | input | NIN x CLW | Per-input service class of the flit |
| req_kind | input | NIN x 2 | Per-input flit kind (00 body, 01 head, 10 tail, 11 single) |
| req_data | input | NIN x DW | Per-input flit payload |
| cred_ret | input | NCLS | Per-class credit-return pulse from downstream |
| in_ready | output | NIN | Grant to the input whose flit is taken this cycle |
| out_valid | output | 1 | Registered link flit valid |
| out_cls | output | CLW | Class of the link flit |
| out_kind | output | 2 | Kind of the link flit |
| out_data | output | DW | Payload of the link flit |

## Verification
The bench builds the block with three inputs, four classes and a downstream depth of two. Three inputs force the round-robin pointer to wrap at a count that is not a power of two. A depth of two lets a class run out of credit after two flits, so stalls and the saturating cap on returns are reachable within a few cycles. The four classes allow head, body and tail flits of a bound packet to be interleaved with single flits of a higher-priority class.

// File: rtl/qos_wh_pkg.sv
package qos_wh_pkg;

    typedef enum logic [1:0] {
        FK_BODY = 2'b00,
        FK_HEAD = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } flit_kind_e;

    // head and single flits both open a packet
    function automatic logic opens_pkt(input logic [1:0] kind);
        return kind[0];
    endfunction

endpackage

// File: rtl/qos_rr_pick.sv
module qos_rr_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(ptr) + k) % N;
            if (!any && req[j]) begin
                any    = 1'b1;
                gnt[j] = 1'b1;
                idx    = IW'(j);
            end
        end
    end
endmodule

// File: rtl/qos_credit_cnt.sv
module qos_credit_cnt #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          give,
    output logic [CW-1:0] cnt,
    output logic          avail
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (take && !give)
            cnt_d = cnt_q - 1'b1;
        else if (give && !take && cnt_q != CW'(DEPTH))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= CW'(DEPTH);
        else     cnt_q <= cnt_d;
    end

    assign cnt   = cnt_q;
    assign avail = (cnt_q != '0);
endmodule

// File: rtl/qos_wh_sched.sv
module qos_wh_sched
    import qos_wh_pkg::*;
#(
    parameter int NIN   = 4,
    parameter int NCLS  = 4,
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    localparam int CLW  = (NCLS > 1) ? $clog2(NCLS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NIN-1:0]            req_valid,
    input  logic [NIN-1:0][CLW-1:0]   req_cls,
    input  logic [NIN-1:0][1:0]       req_kind,
    input  logic [NIN-1:0][DW-1:0]    req_data,
    input  logic [NCLS-1:0]           cred_ret,
    output logic [NIN-1:0]            in_ready,
    output logic                      out_valid,
    output logic [CLW-1:0]            out_cls,
    output logic [1:0]                out_kind,
    output logic [DW-1:0]             out_data
);
    localparam int IW = (NIN > 1) ? $clog2(NIN) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [NCLS-1:0]          lock_v;
        logic [NCLS-1:0][IW-1:0]  lock_in;
        logic [NCLS-1:0][IW-1:0]  ptr;
        logic                     out_v;
        logic [CLW-1:0]           out_cls;
        logic [1:0]               out_kind;
        logic [DW-1:0]            out_data;
    } st_t;

    st_t st_d, st_q;

    logic [NCLS-1:0][NIN-1:0] elig;
    logic [NCLS-1:0][NIN-1:0] cgnt;
    logic [NCLS-1:0][IW-1:0]  cidx;
    logic [NCLS-1:0]          cany;
    logic [NCLS-1:0]          cred_ok;
    logic [NCLS-1:0][CW-1:0]  cred_q;
    logic [NCLS-1:0]          take;
    logic                     win_any;
    logic [CLW-1:0]           win_cls;
    logic [IW-1:0]            win_idx;
    logic [1:0]               win_kind;

    // eligibility per class and input
    always_comb begin
        for (int c = 0; c < NCLS; c++) begin
            for (int i = 0; i < NIN; i++) begin
                logic hit;
                hit = req_valid[i] && (req_cls[i] == CLW'(c)) && cred_ok[c];
                if (st_q.lock_v[c])
                    elig[c][i] = hit && (st_q.lock_in[c] == IW'(i)) && !opens_pkt(req_kind[i]);
                else
                    elig[c][i] = hit && opens_pkt(req_kind[i]);
            end
        end
    end

    for (genvar c = 0; c < NCLS; c++) begin : g_cls
        qos_rr_pick #(.N(NIN)) u_pick (
            .req (elig[c]),
            .ptr (st_q.ptr[c]),
            .gnt (cgnt[c]),
            .idx (cidx[c]),
            .any (cany[c])
        );
        qos_credit_cnt #(.DEPTH(DEPTH)) u_cred (
            .clk   (clk),
            .rst   (rst),
            .take  (take[c]),
            .give  (cred_ret[c]),
            .cnt   (cred_q[c]),
            .avail (cred_ok[c])
        );
    end

    always_comb begin
        win_any = 1'b0;
        win_cls = '0;
        for (int c = NCLS - 1; c >= 0; c--) begin
            if (cany[c]) begin
                win_any = 1'b1;
                win_cls = CLW'(c);
            end
        end
        win_idx  = cidx[win_cls];
        win_kind = req_kind[win_idx];
        take     = '0;
        in_ready = '0;
        if (win_any) begin
            take[win_cls] = 1'b1;
            in_ready      = cgnt[win_cls];
        end

        st_d       = st_q;
        st_d.out_v = win_any;
        if (win_any) begin
            st_d.out_cls           = win_cls;
            st_d.out_kind          = win_kind;
            st_d.out_data          = req_data[win_idx];
            st_d.ptr[win_cls]      = (win_idx == IW'(NIN - 1)) ? '0 : win_idx + 1'b1;
            if (win_kind == FK_HEAD) begin
                st_d.lock_v[win_cls]  = 1'b1;
                st_d.lock_in[win_cls] = win_idx;
            end else if (win_kind == FK_TAIL) begin
                st_d.lock_v[win_cls]  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.out_v;
    assign out_cls   = st_q.out_cls;
    assign out_kind  = st_q.out_kind;
    assign out_data  = st_q.out_data;
endmodule

// File: rtl/qos_wh_sched_chk.sv
module qos_wh_sched_chk #(
    parameter int NIN   = 4,
    parameter int NCLS  = 4,
    parameter int DEPTH = 4,
    localparam int CLW  = (NCLS > 1) ? $clog2(NCLS) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NIN-1:0]           req_valid,
    input logic [NIN-1:0]           in_ready,
    input logic                     out_valid,
    input logic                     win_any,
    input logic [CLW-1:0]           win_cls,
    input logic [NCLS-1:0][CW-1:0]  cred_q
);
    AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(in_ready)); // R9
    AST_READY_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        (in_ready & ~req_valid) == '0); // R9
    AST_GRANT_TO_LINK: assert property (@(posedge clk) disable iff (rst)
        (|in_ready) |=> out_valid); // R9
    AST_IDLE_LINK: assert property (@(posedge clk) disable iff (rst)
        !(|in_ready) |=> !out_valid); // R9
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !out_valid); // R1
    AST_NO_EMPTY_SEND: assert property (@(posedge clk) disable iff (rst)
        win_any |-> cred_q[win_cls] != '0); // R2

    for (genvar c = 0; c < NCLS; c++) begin : g_cap
        AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (rst)
            cred_q[c] <= CW'(DEPTH)); // R3
    end
endmodule

bind qos_wh_sched qos_wh_sched_chk #(.NIN(NIN), .NCLS(NCLS), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .win_any   (win_any),
    .win_cls   (win_cls),
    .cred_q    (cred_q)
);

// File: tb/qos_wh_sched_bench.sv
module qos_wh_sched_bench;
    localparam int NIN = 3, NCLS = 4, DEPTH = 2, DW = 8;
    localparam logic [1:0] BODY = 2'b00, HEAD = 2'b01, TAIL = 2'b10, SOLO = 2'b11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NIN-1:0]          req_valid = '0;
    logic [NIN-1:0][1:0]     req_cls   = '0;
    logic [NIN-1:0][1:0]     req_kind  = '0;
    logic [NIN-1:0][DW-1:0]  req_data  = '0;
    logic [NCLS-1:0]         cred_ret  = '0;
    logic [NIN-1:0]          in_ready;
    logic                    out_valid;
    logic [1:0]              out_cls;
    logic [1:0]              out_kind;
    logic [DW-1:0]           out_data;

    int nchk = 0, nfail = 0, nstep = 0;
    bit done = 1'b0;
    logic [11:0] expq[$];

    always #4 clk = ~clk;

    qos_wh_sched #(.NIN(NIN), .NCLS(NCLS), .DEPTH(DEPTH), .DW(DW)) u_qos_wh_sched (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cls(req_cls),
        .req_kind(req_kind), .req_data(req_data), .cred_ret(cred_ret),
        .in_ready(in_ready), .out_valid(out_valid), .out_cls(out_cls),
        .out_kind(out_kind), .out_data(out_data)
    );

    task automatic clr();
        req_valid = '0;
        cred_ret  = '0;
    endtask

    task automatic put(input int i, input logic [1:0] c, input logic [1:0] k);
        req_valid[i] = 1'b1;
        req_cls[i]   = c;
        req_kind[i]  = k;
        req_data[i]  = DW'(nstep * 4 + i);
    endtask

    // driver: check grant, push the expected link flit
    task automatic go(input logic [NIN-1:0] exp, input string tag);
        #1;
        nchk++;
        if (in_ready !== exp) begin
            nfail++;
            $display("FAIL %s: in_ready=%b expected %b", tag, in_ready, exp);
        end
        for (int i = 0; i < NIN; i++)
            if (exp[i]) expq.push_back({req_cls[i], req_kind[i], req_data[i]});
        nstep++;
        @(posedge clk);
        @(negedge clk);
    endtask

    // monitor: each pushed flit must appear on the next negedge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (expq.size() > 0 || out_valid)) begin
                nchk++;
                if (expq.size() == 0) begin
                    nfail++;
                    $display("FAIL R9: out_valid=1 expected 0");
                end else begin
                    logic [11:0] e;
                    e = expq.pop_front();
                    if (out_valid !== 1'b1 || {out_cls, out_kind, out_data} !== e) begin
                        nfail++;
                        $display("FAIL R9: link v=%b flit=%h expected v=1 flit=%h",
                                 out_valid, {out_cls, out_kind, out_data}, e);
                    end
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clr(); go(3'b000, "R1 idle after reset");

        // R5 round robin in class 0, credits kept topped up
        clr(); cred_ret[0] = 1; put(0, 0, SOLO); put(1, 0, SOLO); put(2, 0, SOLO); go(3'b001, "R1 R5 pointer starts at 0");
        clr(); cred_ret[0] = 1; put(0, 0, SOLO); put(1, 0, SOLO); put(2, 0, SOLO); go(3'b010, "R5 rotate");
        clr(); cred_ret[0] = 1; put(0, 0, SOLO); put(1, 0, SOLO); put(2, 0, SOLO); go(3'b100, "R5 rotate");
        clr(); cred_ret[0] = 1; put(0, 0, SOLO); put(1, 0, SOLO); put(2, 0, SOLO); go(3'b001, "R5 wrap");
        clr(); cred_ret[0] = 1; put(1, 0, SOLO); put(2, 0, SOLO); go(3'b010, "R5 ptr 1");
        clr(); cred_ret[0] = 1; put(1, 0, SOLO); put(2, 0, SOLO); go(3'b100, "R5 ptr 2");

        // R4 class priority
        clr(); put(0, 3, SOLO); put(1, 1, SOLO); put(2, 2, SOLO); go(3'b010, "R4 class 1 first");
        clr(); put(0, 3, SOLO); put(2, 2, SOLO); go(3'b100, "R4 class 2 next");
        clr(); put(0, 3, SOLO); go(3'b001, "R4 class 3 last");

        // R2 / R3 credits: class 2 has 1 left
        clr(); put(2, 2, SOLO); go(3'b100, "R3 last credit used");
        clr(); put(2, 2, SOLO); cred_ret[2] = 1; go(3'b000, "R2 stall at zero, R3 no same-cycle bypass");
        clr(); put(2, 2, SOLO); go(3'b100, "R3 returned credit used");
        clr(); put(2, 2, SOLO); go(3'b000, "R2 stall again");

        // R3 cap: class 3 has 1, three returns saturate at 2
        clr(); cred_ret[3] = 1; go(3'b000, "R3 return");
        clr(); cred_ret[3] = 1; go(3'b000, "R3 return at full");
        clr(); cred_ret[3] = 1; go(3'b000, "R3 return at full");
        clr(); put(0, 3, SOLO); go(3'b001, "R3 cap first");
        clr(); put(0, 3, SOLO); go(3'b001, "R3 cap second");
        clr(); put(0, 3, SOLO); go(3'b000, "R3 cap third stalls");

        // R6 / R7 / R8 wormhole binding in class 1 (pointer at 2)
        clr(); cred_ret[1] = 1; put(0, 1, HEAD); put(1, 1, HEAD); go(3'b001, "R7 head binds input 0");
        clr(); cred_ret[1] = 1; put(0, 1, BODY); put(1, 1, HEAD); go(3'b001, "R7 bound input only");
        clr(); cred_ret[1] = 1; put(0, 1, BODY); put(1, 1, HEAD); put(2, 0, SOLO); go(3'b100, "R8 higher class cuts in");
        clr(); cred_ret[1] = 1; put(0, 1, TAIL); put(1, 1, HEAD); go(3'b001, "R8 binding kept, R7 tail");
        clr(); cred_ret[1] = 1; put(1, 1, HEAD); go(3'b010, "R7 released");
        clr(); cred_ret[1] = 1; put(1, 1, TAIL); go(3'b010, "R7 tail of second packet");
        clr(); put(2, 0, BODY); go(3'b000, "R6 body on unbound class");
        clr(); put(2, 0, TAIL); go(3'b000, "R6 tail on unbound class");
        clr(); put(2, 0, SOLO); go(3'b100, "R6 single still accepted");

        clr();
        repeat (2) @(negedge clk);
        nchk++;
        if (expq.size() != 0) begin
            nfail++;
            $display("FAIL R9: %0d flits never reached the link, expected 0", expq.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule